// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial control port slave that gives a host write and read access to a small bank of 8-bit configuration registers. A transaction opens when chip select goes low. A 16-bit instruction comes first. It carries a read/write flag, a byte-count code and a 13-bit register address. Data bytes follow, and after each byte the address steps automatically. The serial lines are synchronised into the system clock. Input bits are taken on rising serial-clock edges, and read bits are launched on falling ones.

The port runs in three-wire mode, where read data shares the data pin, or in four-wire mode, with a separate output pin. Frames go MSB-first with the address stepping down, or LSB-first with the address stepping up. Both settings come from a control register whose low nibble mirrors its high nibble, so the byte decodes the same in either order. Configuration writes land in a buffer bank. A self-clearing commit bit copies the whole buffer into the active bank, and the active bank drives the block's configuration output. A select bit chooses which bank a read returns. A self-clearing soft reset reloads everything, either from a parallel load port or from zero defaults. The map also holds a fixed identification byte and two free user-ID bytes.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset the port is in three-wire mode: read data is driven on `sdio_out` with `sdio_oe` high during the data phase of a read, and `sdo_oe` stays low.
- R2: After reset, frames are MSB-first and the register address decrements by one after each data byte.
- R3: The instruction word is bit 15 = read (1) or write (0), bits 14:13 = byte count (00 one byte, 01 two, 10 three, 11 streaming until chip select rises), bits 12:0 = address. Once the counted bytes are done, further serial clocks neither write nor drive any output.
- R4: Writing control register 0x000 with bit 6 set makes the following transactions LSB-first for instruction and data, and the address then increments after each byte.
- R5: Writing control bit 7 set selects four-wire mode for the following transactions: read data appears on `sdo_out` with `sdo_oe` high, and `sdio_oe` stays low. The two enables are never high together.
- R6: Writes to configuration registers (0x001, 0x002, 0x005, 0x006 and 0x008 upward) change only the buffer bank. Writing register 0x007 with bit 0 set copies every buffer byte into the active bank (`act_cfg`, byte i at bits 8i+7:8i). The active bank changes at no other time except soft reset.
- R7: Register 0x004 bit 0 selects the readback bank (0 buffer, 1 active). Register 0x007 always reads 0x00.
- R8: Register 0x003 reads the `ID_CODE` parameter, and writes to it have no effect.
- R9: Writing control bit 5 while `load_sel` is low clears every register in both banks to 0x00 and returns the port to three-wire, MSB-first mode. The bit reads back as 0.
- R10: Writing control bit 5 while `load_sel` is high loads both banks from `load_vals` (byte i at bits 8i+7:8i). Mode bits 7 and 6 are taken from byte 0 and the bank select from byte 4 bit 0.
- R11: Raising `csb` ends a transaction at once. A partly shifted byte is not written, and both output enables drop.
- R12: Register 0x000 reads as {b7, b6, 0, 0, 0, 0, b6, b7}, where b7 is the pin-mode bit and b6 the order bit.
- R13: Addresses at or above `NUM_REGS` ignore writes and read 0x00. User-ID registers 0x005 and 0x006 reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| csb | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Serial data in (shared data pin, input side) |
| sdio_out | output | 1 | Read data for the shared data pin |
| sdio_oe | output | 1 | Output enable of the shared data pin |
| sdo_out | output | 1 | Read data for the separate output pin |
| sdo_oe | output | 1 | Output enable of the separate output pin |
| load_sel | input | 1 | Soft-reset source: 1 load port, 0 zero defaults |
| load_vals | input | NUM_REGS*8 | Parallel stored values for soft reset |
| act_cfg | output | NUM_REGS*8 | Active register bank |

## Verification
The bench builds the block with `NUM_REGS` = 10 and `ID_CODE` = 0x5A. Ten registers put general configuration bytes at 0x008 and 0x009 above the commit register, so counted and streaming transfers run across the special addresses. Addresses such as 0x00C and 0x1FFF then fall outside the bank. The non-zero identification byte separates a correct ID read from a cleared register. Both frame orders and both pin modes are exercised against a behavioural register model.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    localparam int INSTR_W    = 16;
    localparam int ADDR_W     = 13;
    localparam int REG_CTRL   = 0;
    localparam int REG_ID     = 3;
    localparam int REG_RBSEL  = 4;
    localparam int REG_COMMIT = 7;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_INSTR = 2'd1,
        PH_DATA  = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic csb,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic sdi_s
);
    typedef struct packed {
        logic [1:0] ck;
        logic [1:0] cs;
        logic [1:0] di;
        logic       ck_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d.ck      = {q.ck[0], sclk};
        d.cs      = {q.cs[0], csb};
        d.di      = {q.di[0], sdi};
        d.ck_prev = q.ck[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ck: 2'b00, cs: 2'b11, di: 2'b00, ck_prev: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sclk_rise = q.ck[1] & ~q.ck_prev;
    assign sclk_fall = ~q.ck[1] & q.ck_prev;
    assign cs_act    = ~q.cs[1];
    assign sdi_s     = q.di[1];
endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank
    import spi_cfg_pkg::*;
#(
    parameter int          NUM_REGS = 10,
    parameter logic [7:0]  ID_CODE  = 8'h5A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic                  load_sel,
    input  logic [NUM_REGS*8-1:0] load_vals,
    output logic [7:0]            rd_data,
    output logic                  pin4,
    output logic                  lsb_first,
    output logic [NUM_REGS*8-1:0] act_cfg
);
    localparam int IDX_W = $clog2(NUM_REGS);

    typedef struct packed {
        logic [NUM_REGS-1:0][7:0] bufb;
        logic [NUM_REGS-1:0][7:0] actb;
        logic                     pin4;
        logic                     lsb;
        logic                     rbsel;
    } bank_t;

    bank_t q, d;

    logic             w_hit, r_hit, reload;
    logic [IDX_W-1:0] w_idx, r_idx;

    always_comb begin
        d      = q;
        w_hit  = wr_en && (wr_addr < ADDR_W'(NUM_REGS));
        w_idx  = wr_addr[IDX_W-1:0];
        reload = w_hit && (w_idx == IDX_W'(REG_CTRL)) && wr_data[5];

        if (reload) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                d.bufb[i] = load_sel ? load_vals[i*8 +: 8] : 8'h00;
                d.actb[i] = load_sel ? load_vals[i*8 +: 8] : 8'h00;
            end
            d.pin4  = load_sel & load_vals[REG_CTRL*8 + 7];
            d.lsb   = load_sel & load_vals[REG_CTRL*8 + 6];
            d.rbsel = load_sel & load_vals[REG_RBSEL*8];
        end else if (w_hit) begin
            if (w_idx == IDX_W'(REG_CTRL)) begin
                d.pin4 = wr_data[7];
                d.lsb  = wr_data[6];
            end else if (w_idx == IDX_W'(REG_ID)) begin
                d.rbsel = q.rbsel;
            end else if (w_idx == IDX_W'(REG_RBSEL)) begin
                d.rbsel = wr_data[0];
            end else if (w_idx == IDX_W'(REG_COMMIT)) begin
                if (wr_data[0]) d.actb = q.bufb;
            end else begin
                d.bufb[w_idx] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        r_hit   = rd_addr < ADDR_W'(NUM_REGS);
        r_idx   = rd_addr[IDX_W-1:0];
        rd_data = 8'h00;
        if (r_hit) begin
            if (r_idx == IDX_W'(REG_CTRL))
                rd_data = {q.pin4, q.lsb, 4'b0000, q.lsb, q.pin4};
            else if (r_idx == IDX_W'(REG_ID))
                rd_data = ID_CODE;
            else if (r_idx == IDX_W'(REG_RBSEL))
                rd_data = {7'b0, q.rbsel};
            else if (r_idx == IDX_W'(REG_COMMIT))
                rd_data = 8'h00;
            else
                rd_data = q.rbsel ? q.actb[r_idx] : q.bufb[r_idx];
        end
    end

    assign pin4      = q.pin4;
    assign lsb_first = q.lsb;
    assign act_cfg   = q.actb;
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int         NUM_REGS = 10,
    parameter logic [7:0] ID_CODE  = 8'h5A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  csb,
    input  logic                  sdio_in,
    output logic                  sdio_out,
    output logic                  sdio_oe,
    output logic                  sdo_out,
    output logic                  sdo_oe,
    input  logic                  load_sel,
    input  logic [NUM_REGS*8-1:0] load_vals,
    output logic [NUM_REGS*8-1:0] act_cfg
);
    typedef struct packed {
        phase_e              phase;
        logic [3:0]          bcnt;
        logic [INSTR_W-1:0]  sh;
        logic                rw;
        logic [1:0]          cnt;
        logic [1:0]          nbytes;
        logic [ADDR_W-1:0]   addr;
        logic                lsb;
        logic                pin4;
        logic                out;
    } port_t;

    port_t q, d;

    logic              rise, fall, cs_act, sdi;
    logic              wr_en;
    logic [7:0]        rd_data;
    logic              bank_pin4, bank_lsb;
    logic [7:0]        nb;
    logic [INSTR_W-1:0] nw;
    logic              in_done;

    spi_cfg_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .csb       (csb),
        .sdi       (sdio_in),
        .sclk_rise (rise),
        .sclk_fall (fall),
        .cs_act    (cs_act),
        .sdi_s     (sdi)
    );

    spi_cfg_regbank #(.NUM_REGS(NUM_REGS), .ID_CODE(ID_CODE)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (q.addr),
        .wr_data   (nb),
        .rd_addr   (q.addr),
        .load_sel  (load_sel),
        .load_vals (load_vals),
        .rd_data   (rd_data),
        .pin4      (bank_pin4),
        .lsb_first (bank_lsb),
        .act_cfg   (act_cfg)
    );

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        nb    = q.lsb ? {sdi, q.sh[7:1]}  : {q.sh[6:0], sdi};
        nw    = q.lsb ? {sdi, q.sh[15:1]} : {q.sh[14:0], sdi};

        if (!cs_act) begin
            d.phase = PH_IDLE;
            d.out   = 1'b0;
        end else begin
            case (q.phase)
                PH_IDLE: begin
                    d.phase = PH_INSTR;
                    d.bcnt  = 4'd0;
                    d.lsb   = bank_lsb;
                    d.pin4  = bank_pin4;
                end
                PH_INSTR: begin
                    if (rise) begin
                        d.sh   = nw;
                        d.bcnt = q.bcnt + 4'd1;
                        if (q.bcnt == 4'd15) begin
                            d.rw     = nw[15];
                            d.cnt    = nw[14:13];
                            d.addr   = nw[ADDR_W-1:0];
                            d.phase  = PH_DATA;
                            d.bcnt   = 4'd0;
                            d.nbytes = 2'd0;
                        end
                    end
                end
                PH_DATA: begin
                    if (rise) begin
                        d.sh   = {q.sh[15:8], nb};
                        d.bcnt = q.bcnt + 4'd1;
                        if (q.bcnt == 4'd7) begin
                            d.bcnt = 4'd0;
                            wr_en  = !q.rw;
                            d.addr = q.lsb ? q.addr + 1'b1 : q.addr - 1'b1;
                            if (q.cnt != 2'd3 && q.nbytes == q.cnt)
                                d.phase = PH_DONE;
                            else
                                d.nbytes = q.nbytes + 2'd1;
                        end
                    end else if (fall && q.rw) begin
                        d.out = rd_data[q.lsb ? q.bcnt[2:0] : 3'd7 - q.bcnt[2:0]];
                    end
                end
                default: d.phase = PH_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign in_done  = (q.phase == PH_DONE);
    assign sdio_out = q.out;
    assign sdo_out  = q.out;
    assign sdio_oe  = (q.phase == PH_DATA) && q.rw && !q.pin4;
    assign sdo_oe   = (q.phase == PH_DATA) && q.rw && q.pin4;
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk #(
    parameter int W = 80
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sdio_oe,
    input logic         sdo_oe,
    input logic         cs_act,
    input logic         wr_en,
    input logic         in_done,
    input logic [W-1:0] act_cfg
);
    assert_oe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe && sdo_oe));

    assert_cs_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!sdio_oe && !sdo_oe));

    assert_act_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(act_cfg));

    assert_done_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_done |-> !wr_en);
endmodule

bind spi_cfg_port spi_cfg_port_chk #(.W(NUM_REGS*8)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdio_oe (sdio_oe),
    .sdo_oe  (sdo_oe),
    .cs_act  (cs_act),
    .wr_en   (wr_en),
    .in_done (in_done),
    .act_cfg (act_cfg)
);

// File: tb/tb_spi_cfg_port.sv
module tb_spi_cfg_port;
    localparam int         NR = 10;
    localparam logic [7:0] ID = 8'h5A;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, csb = 1'b1, sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo_out, sdo_oe;
    logic load_sel = 1'b0;
    logic [NR*8-1:0] load_vals = '0;
    logic [NR*8-1:0] act_cfg;

    always #5 clk = ~clk;

    spi_cfg_port #(.NUM_REGS(NR), .ID_CODE(ID)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
        .load_sel(load_sel), .load_vals(load_vals), .act_cfg(act_cfg)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // behavioural register model
    logic [7:0] mb[NR], ma[NR];
    logic mp4 = 0, mls = 0, mrb = 0;
    logic [7:0] wdat[4];
    logic [7:0] rdat[4];

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_rd(input int a);
        if (a >= NR) return 8'h00;
        case (a)
            0: return {mp4, mls, 4'b0000, mls, mp4};
            3: return ID;
            4: return {7'b0, mrb};
            7: return 8'h00;
            default: return mrb ? ma[a] : mb[a];
        endcase
    endfunction

    task automatic m_wr(input int a, input logic [7:0] v);
        if (a >= NR) return;
        case (a)
            0: if (v[5]) begin
                   for (int i = 0; i < NR; i++) begin
                       mb[i] = load_sel ? load_vals[i*8 +: 8] : 8'h00;
                       ma[i] = mb[i];
                   end
                   mp4 = load_sel & load_vals[7];
                   mls = load_sel & load_vals[6];
                   mrb = load_sel & load_vals[32];
               end else begin
                   mp4 = v[7]; mls = v[6];
               end
            3: ;
            4: mrb = v[0];
            7: if (v[0]) for (int i = 0; i < NR; i++) ma[i] = mb[i];
            default: mb[a] = v;
        endcase
    endtask

    task automatic send_bit(input logic b);
        sclk = 1'b0; sdio_in = b;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // rw: 1 read; cc: count code; nb: bytes clocked; cut: abort before data bit number cut (-1 none)
    task automatic xfer(input bit rw, input logic [1:0] cc, input int addr, input int nb,
                        input int cut, input string req);
        logic [15:0] w;
        bit ls, p4, live;
        int lim, a, bitno;
        w  = {rw, cc, 13'(addr)};
        ls = mls; p4 = mp4; live = 1;
        lim = (cc == 2'd3) ? nb : int'(cc) + 1;
        a = addr; bitno = 0;
        csb = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 16; i++) send_bit(ls ? w[i] : w[15-i]);
        for (int b = 0; b < nb; b++) begin
            for (int k = 0; k < 8; k++) begin
                int idx;
                idx = ls ? k : 7 - k;
                if (live && cut >= 0 && bitno == cut) live = 0;
                if (live) begin
                    sclk = 1'b0; sdio_in = wdat[b][idx];
                    repeat (4) @(negedge clk);
                    if (rw && b < lim) begin
                        rdat[b][idx] = p4 ? sdo_out : sdio_out;
                        chk(sdio_oe == !p4 && sdo_oe == p4, p4 ? "R5" : "R1",
                            {sdio_oe, sdo_oe}, {!p4, p4});
                    end else begin
                        chk(!sdio_oe && !sdo_oe, "R3", {sdio_oe, sdo_oe}, 2'b00);
                    end
                    sclk = 1'b1;
                    repeat (4) @(negedge clk);
                    bitno++;
                end
            end
            if (live && b < lim) begin
                if (rw) chk(rdat[b] == m_rd(a), req, rdat[b], m_rd(a));
                else    m_wr(a, wdat[b]);
                a = ls ? ((a + 1) & 16'h1FFF) : ((a - 1) & 16'h1FFF);
            end
        end
        if (!live) begin
            csb = 1'b1;
            repeat (6) @(negedge clk);
            chk(!sdio_oe && !sdo_oe, "R11", {sdio_oe, sdo_oe}, 2'b00);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end else begin
            sclk = 1'b0;
            repeat (4) @(negedge clk);
            csb = 1'b1;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic wr1(input int a, input logic [7:0] v);
        wdat[0] = v;
        xfer(1'b0, 2'd0, a, 1, -1, "wr");
    endtask

    task automatic rd1(input int a, input string req);
        wdat[0] = 8'h00;
        xfer(1'b1, 2'd0, a, 1, -1, req);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin mb[i] = 8'h00; ma[i] = 8'h00; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state
        chk(!sdio_oe && !sdo_oe, "R1", {sdio_oe, sdo_oe}, 2'b00);
        chk(act_cfg == '0, "R6", act_cfg, 0);
        rd1(0, "R12");
        rd1(3, "R8");
        rd1(5, "R13");
        rd1(6, "R13");

        // R2: MSB-first streaming write, address steps down
        wdat[0] = 8'h11; wdat[1] = 8'h22;
        xfer(1'b0, 2'd3, 2, 2, -1, "R2");
        xfer(1'b1, 2'd1, 2, 2, -1, "R2");
        chk(mb[1] == 8'h22 && mb[2] == 8'h11, "R2", {mb[2], mb[1]}, 16'h1122);

        // R3: one-byte count, second byte ignored
        wdat[0] = 8'h33; wdat[1] = 8'h44;
        xfer(1'b0, 2'd0, 9, 2, -1, "R3");
        xfer(1'b1, 2'd1, 9, 3, -1, "R3");

        // R8: identification register is read-only
        wr1(3, 8'hFF);
        rd1(3, "R8");

        // R13: out-of-range address
        wr1(12, 8'h77);
        rd1(12, "R13");
        rd1(13'h1FFF, "R13");

        // R6 / R7: double buffering and readback select
        wr1(4, 8'h01);
        rd1(1, "R7");
        chk(act_cfg[15:8] == 8'h00, "R6", act_cfg[15:8], 8'h00);
        wr1(7, 8'h01);
        chk(act_cfg[15:8] == 8'h22 && act_cfg[79:72] == 8'h33, "R6",
            {act_cfg[79:72], act_cfg[15:8]}, 16'h3322);
        rd1(1, "R6");
        rd1(7, "R7");
        wr1(2, 8'h99);
        rd1(2, "R7");
        wr1(4, 8'h00);
        rd1(2, "R7");

        // R4: LSB-first, address steps up
        wr1(0, 8'h42);
        rd1(0, "R12");
        wdat[0] = 8'hA1; wdat[1] = 8'hB2;
        xfer(1'b0, 2'd1, 5, 2, -1, "R4");
        xfer(1'b1, 2'd1, 5, 2, -1, "R4");
        chk(mb[5] == 8'hA1 && mb[6] == 8'hB2, "R4", {mb[6], mb[5]}, 16'hB2A1);

        // R5: four-wire readback
        wr1(0, 8'hC3);
        rd1(6, "R5");
        xfer(1'b1, 2'd2, 0, 3, -1, "R5");

        // R11: aborted write and aborted read
        wdat[0] = 8'h5C;
        xfer(1'b0, 2'd0, 8, 1, 4, "R11");
        rd1(8, "R11");
        xfer(1'b1, 2'd3, 1, 2, 3, "R11");

        // R9: soft reset to defaults
        load_sel = 1'b0;
        wr1(0, 8'h24);
        chk(act_cfg == '0, "R9", act_cfg, 0);
        rd1(5, "R9");
        rd1(0, "R9");

        // R10: soft reset from the load port
        for (int i = 0; i < NR; i++) load_vals[i*8 +: 8] = 8'(8'h10 + i);
        load_vals[7:0]   = 8'h42;
        load_vals[39:32] = 8'h01;
        load_sel = 1'b1;
        wr1(0, 8'h24);
        chk(act_cfg == load_vals, "R10", act_cfg, load_vals);
        rd1(1, "R10");
        rd1(0, "R10");
        rd1(4, "R10");

        finished = 1;
        summary();
    end
endmodule